// File: doc/BRIEF.md
# Subchannel Command Dispatcher

The dispatcher takes one command at a time from a command queue. A command has three parts: a subchannel index, a method byte address and a 32-bit parameter. Methods below 0x100 are handled inside the block. Methods from 0x100 up to 0x3ffc go out on a forward port to the engine currently bound to the command's subchannel. The block keeps one engine id per subchannel in a binding table. Method 0 rewrites that entry.

The forward port is one valid signal with engine, subchannel, method and parameter fields. Each engine has its own ready input and its own idle input. A command is forwarded as soon as its engine is ready; the block never waits for earlier work to finish. There is one exception. If a command targets a different engine from the one used last, the block first waits until the last-used engine reports idle.

A software engine id marks a subchannel that no hardware engine serves. A command that resolves to that id raises a sticky empty-subchannel error. While the error is set, the block stops taking commands until the host clears it. The built-in methods are:

- a reference-counter load, readable by the host, which first drains the last-used engine;
- a one-cycle notify interrupt;
- a no-operation.

Top module: `cmd_dispatch`

## Requirements
- R1: After reset the block shows `cmd_ready`=1, `fwd_valid`=0, `err_flag`=0, `err_code`=0, `ref_count`=0 and `notify_irq`=0. Every subchannel is bound to the software engine id `SW_ENG`, so a forwarded method on a fresh subchannel raises the error.
- R2: Method 0x000 is bound using its parameter fields:
  - the engine id is taken from parameter bits [20:16];
  - method 0 is forwarded to that engine with `fwd_param` equal to parameter bits [15:0] zero-extended, and with the command's subchannel;
  - after acceptance, later forwards on that subchannel go to the new engine.
- R3: A method in 0x100..0x3ffc is forwarded to the engine bound to its subchannel, with subchannel, method and parameter unchanged.
- R4: While `fwd_valid` is high and `eng_ready[fwd_engine]` is low, every forward field holds its value in the next cycle.
- R5: Switching engines can stall. When the target engine differs from the last-used engine, the last-used engine is not `SW_ENG`, and `eng_idle` of the last-used engine is low, nothing is forwarded. A target equal to the last-used engine never waits for idle.
- R6: A bind or forward whose target is `SW_ENG` has these effects:
  - `err_flag` goes to 1 with `err_code` 2'b01 (empty subchannel);
  - nothing is forwarded;
  - the binding table and the last-used engine stay unchanged.
- R7: `err_flag` stays set, and `cmd_ready` stays low, until `err_clear` is pulsed. After that `err_flag`=0, `err_code`=0 and `cmd_ready`=1.
- R8: Method 0x050 waits until the last-used engine is idle, unless that engine is `SW_ENG`. It then loads its parameter into `ref_count`.
- R9: Method 0x020 produces a `notify_irq` pulse exactly one cycle long. Method 0x008, and every other method below 0x100 not named above, forwards nothing and leaves `ref_count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken when both valid and ready are high |
| cmd_subch | input | 3 | Subchannel index |
| cmd_method | input | 14 | Method byte address |
| cmd_param | input | 32 | Method parameter |
| fwd_valid | output | 1 | Forwarded method present |
| fwd_engine | output | 5 | Target engine id |
| fwd_subch | output | 3 | Subchannel of forwarded method |
| fwd_method | output | 14 | Forwarded method address |
| fwd_param | output | 32 | Forwarded parameter |
| eng_ready | input | 32 | Per-engine accept signal |
| eng_idle | input | 32 | Per-engine idle status |
| ref_count | output | 32 | Host-readable reference counter |
| notify_irq | output | 1 | One-cycle notify interrupt |
| err_flag | output | 1 | Sticky error flag |
| err_code | output | 2 | Error code, 2'b01 = empty subchannel |
| err_clear | input | 1 | Host clear of the error |

## Verification
The bench builds the block with its default parameters:

- eight subchannels;
- a 5-bit engine id, giving 32 engines;
- a 14-bit method address;
- software engine id 0.

These defaults put every subchannel, the full engine-id range and the top method 0x3ffc within reach of the random stream. Directed cases cover the switch stall, the drain before a reference load, forward backpressure and the sticky error. A nonzero software id needs a rebuild with another `SW_ENG`.

// File: rtl/cmd_dispatch_pkg.sv
package cmd_dispatch_pkg;

   typedef enum logic [2:0] {
      K_BIND,
      K_FWD,
      K_NOP,
      K_NOTIFY,
      K_REF
   } cmd_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_CHECK,
      ST_SEND
   } disp_state_e;

   localparam logic [1:0] ERR_NONE        = 2'd0;
   localparam logic [1:0] ERR_EMPTY_SUBCH = 2'd1;

   localparam int unsigned M_BIND     = 'h000;
   localparam int unsigned M_NOP      = 'h008;
   localparam int unsigned M_NOTIFY   = 'h020;
   localparam int unsigned M_REF      = 'h050;
   localparam int unsigned M_FWD_BASE = 'h100;

   localparam int unsigned CLASS_W    = 16;
   localparam int unsigned ENG_LSB    = 16;

endpackage

// File: rtl/cmd_classify.sv
module cmd_classify
   import cmd_dispatch_pkg::*;
#(
   parameter int MTHD_W = 14
) (
   input  logic [MTHD_W-1:0] method,
   output cmd_kind_e         kind
);

   localparam int unsigned MTHD_U = 32'(MTHD_W);

   initial begin
      if (MTHD_U < 9) $error("cmd_classify: MTHD_W too small for forward range");
   end

   always_comb begin
      if (32'(method) >= M_FWD_BASE)    kind = K_FWD;
      else if (32'(method) == M_BIND)   kind = K_BIND;
      else if (32'(method) == M_NOTIFY) kind = K_NOTIFY;
      else if (32'(method) == M_REF)    kind = K_REF;
      else                              kind = K_NOP;
   end

endmodule

// File: rtl/cmd_bind_table.sv
module cmd_bind_table #(
   parameter int NSUB   = 8,
   parameter int ENG_W  = 5,
   parameter int SW_ENG = 0,
   localparam int SUB_W = $clog2(NSUB)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SUB_W-1:0] wr_sub,
   input  logic [ENG_W-1:0] wr_eng,
   input  logic [SUB_W-1:0] rd_sub,
   output logic [ENG_W-1:0] rd_eng
);

   logic [NSUB*ENG_W-1:0] flat;

   for (genvar g = 0; g < NSUB; g++) begin : g_entry
      logic [ENG_W-1:0] eng_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            eng_q <= ENG_W'(SW_ENG);
         else if (wr_en && (wr_sub == SUB_W'(g)))
            eng_q <= wr_eng;
      end
      assign flat[g*ENG_W +: ENG_W] = eng_q;
   end

   assign rd_eng = flat[32'(rd_sub)*ENG_W +: ENG_W];

endmodule

// File: rtl/cmd_dispatch.sv
module cmd_dispatch
   import cmd_dispatch_pkg::*;
#(
   parameter int NSUB    = 8,
   parameter int ENG_W   = 5,
   parameter int MTHD_W  = 14,
   parameter int DATA_W  = 32,
   parameter int SW_ENG  = 0,
   localparam int SUB_W  = $clog2(NSUB),
   localparam int NUM_ENG = 2**ENG_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   output logic               cmd_ready,
   input  logic [SUB_W-1:0]   cmd_subch,
   input  logic [MTHD_W-1:0]  cmd_method,
   input  logic [DATA_W-1:0]  cmd_param,
   output logic               fwd_valid,
   output logic [ENG_W-1:0]   fwd_engine,
   output logic [SUB_W-1:0]   fwd_subch,
   output logic [MTHD_W-1:0]  fwd_method,
   output logic [DATA_W-1:0]  fwd_param,
   input  logic [NUM_ENG-1:0] eng_ready,
   input  logic [NUM_ENG-1:0] eng_idle,
   output logic [DATA_W-1:0]  ref_count,
   output logic               notify_irq,
   output logic               err_flag,
   output logic [1:0]         err_code,
   input  logic               err_clear
);

   localparam logic [ENG_W-1:0] SW_ID = ENG_W'(SW_ENG);

   if (NSUB < 2 || (NSUB & (NSUB - 1)) != 0) begin : g_bad_nsub
      $error("cmd_dispatch: NSUB must be a power of two, at least 2");
   end
   if (DATA_W < 32'(CLASS_W) + ENG_W) begin : g_bad_data
      $error("cmd_dispatch: DATA_W cannot hold class and engine fields");
   end
   if (SW_ENG < 0 || SW_ENG >= NUM_ENG) begin : g_bad_sw
      $error("cmd_dispatch: SW_ENG outside engine id range");
   end

   disp_state_e        state_q;
   cmd_kind_e          kind_d, kind_q;
   logic [SUB_W-1:0]   sub_q;
   logic [MTHD_W-1:0]  mthd_q;
   logic [DATA_W-1:0]  param_q;
   logic [ENG_W-1:0]   last_q;
   logic [DATA_W-1:0]  ref_q;
   logic               notify_q;
   logic               err_q;
   logic [1:0]         code_q;

   logic [ENG_W-1:0]   bound_eng;
   logic [ENG_W-1:0]   target;
   logic               last_drained;
   logic               switch_ok;
   logic               accept;
   logic               send_done;
   logic               tbl_wr;

   cmd_classify #(.MTHD_W(MTHD_W)) u_classify (
      .method (cmd_method),
      .kind   (kind_d)
   );

   cmd_bind_table #(.NSUB(NSUB), .ENG_W(ENG_W), .SW_ENG(SW_ENG)) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (tbl_wr),
      .wr_sub (sub_q),
      .wr_eng (target),
      .rd_sub (sub_q),
      .rd_eng (bound_eng)
   );

   assign target       = (kind_q == K_BIND) ? param_q[ENG_LSB +: ENG_W] : bound_eng;
   assign last_drained = (last_q == SW_ID) || eng_idle[last_q];
   assign switch_ok    = (target == last_q) || last_drained;
   assign cmd_ready    = (state_q == ST_IDLE) && !err_q;
   assign accept       = cmd_valid && cmd_ready;
   assign send_done    = (state_q == ST_SEND) && eng_ready[target];
   assign tbl_wr       = send_done && (kind_q == K_BIND);

   assign fwd_valid  = (state_q == ST_SEND);
   assign fwd_engine = target;
   assign fwd_subch  = sub_q;
   assign fwd_method = mthd_q;
   assign fwd_param  = (kind_q == K_BIND) ? DATA_W'(param_q[CLASS_W-1:0]) : param_q;

   assign ref_count  = ref_q;
   assign notify_irq = notify_q;
   assign err_flag   = err_q;
   assign err_code   = code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q   <= '0;
         mthd_q  <= '0;
         param_q <= '0;
         kind_q  <= K_NOP;
      end else if (accept) begin
         sub_q   <= cmd_subch;
         mthd_q  <= cmd_method;
         param_q <= cmd_param;
         kind_q  <= kind_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         last_q   <= SW_ID;
         ref_q    <= '0;
         notify_q <= 1'b0;
         err_q    <= 1'b0;
         code_q   <= ERR_NONE;
      end else begin
         notify_q <= 1'b0;
         if (err_clear) begin
            err_q  <= 1'b0;
            code_q <= ERR_NONE;
         end
         unique case (state_q)
            ST_IDLE: begin
               if (accept) state_q <= ST_CHECK;
            end
            ST_CHECK: begin
               unique case (kind_q)
                  K_NOTIFY: begin
                     notify_q <= 1'b1;
                     state_q  <= ST_IDLE;
                  end
                  K_REF: begin
                     if (last_drained) begin
                        ref_q   <= param_q;
                        state_q <= ST_IDLE;
                     end
                  end
                  K_BIND, K_FWD: begin
                     if (switch_ok) begin
                        if (target == SW_ID) begin
                           err_q   <= 1'b1;
                           code_q  <= ERR_EMPTY_SUBCH;
                           state_q <= ST_IDLE;
                        end else begin
                           state_q <= ST_SEND;
                        end
                     end
                  end
                  default: state_q <= ST_IDLE;
               endcase
            end
            ST_SEND: begin
               if (send_done) begin
                  last_q  <= target;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cmd_dispatch_chk.sv
module cmd_dispatch_chk #(
   parameter int NSUB    = 8,
   parameter int ENG_W   = 5,
   parameter int MTHD_W  = 14,
   parameter int DATA_W  = 32,
   parameter int SW_ENG  = 0,
   localparam int SUB_W  = $clog2(NSUB),
   localparam int NUM_ENG = 2**ENG_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_ready,
   input logic               fwd_valid,
   input logic [ENG_W-1:0]   fwd_engine,
   input logic [SUB_W-1:0]   fwd_subch,
   input logic [MTHD_W-1:0]  fwd_method,
   input logic [DATA_W-1:0]  fwd_param,
   input logic [NUM_ENG-1:0] eng_ready,
   input logic [NUM_ENG-1:0] eng_idle,
   input logic               notify_irq,
   input logic               err_flag,
   input logic               err_clear,
   input logic [ENG_W-1:0]   last_eng
);

   localparam logic [ENG_W-1:0] SW_ID = ENG_W'(SW_ENG);

   assert_fwd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid && !eng_ready[fwd_engine] |=> fwd_valid && $stable(fwd_engine) &&
         $stable(fwd_subch) && $stable(fwd_method) && $stable(fwd_param));

   assert_switch_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fwd_valid) && fwd_engine != last_eng && last_eng != SW_ID |-> $past(eng_idle[last_eng]));

   assert_no_sw_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> fwd_engine != SW_ID);

   assert_err_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |-> !cmd_ready);

   assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag && !err_clear |=> err_flag);

   assert_notify_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      notify_irq |=> !notify_irq);

endmodule

bind cmd_dispatch cmd_dispatch_chk #(
   .NSUB(NSUB), .ENG_W(ENG_W), .MTHD_W(MTHD_W), .DATA_W(DATA_W), .SW_ENG(SW_ENG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_ready  (cmd_ready),
   .fwd_valid  (fwd_valid),
   .fwd_engine (fwd_engine),
   .fwd_subch  (fwd_subch),
   .fwd_method (fwd_method),
   .fwd_param  (fwd_param),
   .eng_ready  (eng_ready),
   .eng_idle   (eng_idle),
   .notify_irq (notify_irq),
   .err_flag   (err_flag),
   .err_clear  (err_clear),
   .last_eng   (last_q)
);

// File: tb/test_cmd_dispatch.sv
module test_cmd_dispatch;

   localparam int CLK_PERIOD = 10;
   localparam int SW = 0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [2:0]  cmd_subch = '0;
   logic [13:0] cmd_method = '0;
   logic [31:0] cmd_param = '0;
   logic        fwd_valid;
   logic [4:0]  fwd_engine;
   logic [2:0]  fwd_subch;
   logic [13:0] fwd_method;
   logic [31:0] fwd_param;
   logic [31:0] eng_ready = '1;
   logic [31:0] eng_idle = '1;
   logic [31:0] ref_count;
   logic        notify_irq;
   logic        err_flag;
   logic [1:0]  err_code;
   logic        err_clear = 1'b0;

   int checks = 0;
   int failures = 0;

   logic [4:0]  mb [8];
   logic [4:0]  ml;
   logic [31:0] mref;

   cmd_dispatch i_cmd_dispatch (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_subch(cmd_subch), .cmd_method(cmd_method), .cmd_param(cmd_param),
      .fwd_valid(fwd_valid), .fwd_engine(fwd_engine), .fwd_subch(fwd_subch),
      .fwd_method(fwd_method), .fwd_param(fwd_param), .eng_ready(eng_ready),
      .eng_idle(eng_idle), .ref_count(ref_count), .notify_irq(notify_irq),
      .err_flag(err_flag), .err_code(err_code), .err_clear(err_clear)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   initial begin
      #(CLK_PERIOD * 150000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // 0 bind, 1 forward, 2 no-op, 3 notify, 4 reference load
   function automatic int f_kind(input logic [13:0] m);
      if (m >= 14'h100) return 1;
      if (m == 14'h000) return 0;
      if (m == 14'h020) return 3;
      if (m == 14'h050) return 4;
      return 2;
   endfunction

   function automatic logic [4:0] f_target(input int k, input logic [2:0] s, input logic [31:0] p);
      return (k == 0) ? p[20:16] : mb[s];
   endfunction

   function automatic logic [31:0] f_fparam(input int k, input logic [31:0] p);
      return (k == 0) ? {16'h0, p[15:0]} : p;
   endfunction

   task automatic issue(input logic [2:0] s, input logic [13:0] m, input logic [31:0] p);
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1; cmd_subch = s; cmd_method = m; cmd_param = p;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic clear_err();
      @(negedge clk);
      err_clear = 1'b1;
      @(negedge clk);
      err_clear = 1'b0;
      chk(err_flag == 1'b0 && err_code == 2'd0, "R7", "err after clear", {30'd0, err_code}, 32'd0);
      chk(cmd_ready == 1'b1, "R7", "ready after clear", {31'd0, cmd_ready}, 32'd1);
   endtask

   // finishes the command issued last and checks all outcomes against the model
   task automatic finish_cmd(input logic [2:0] s, input logic [13:0] m, input logic [31:0] p);
      int k = f_kind(m);
      bit got = 0;
      bit notif = 0;
      logic [4:0] ge = '0;
      logic [2:0] gs = '0;
      logic [13:0] gm = '0;
      logic [31:0] gp = '0;
      logic [4:0] tgt = f_target(k, s, p);
      for (int n = 0; n < 2000; n++) begin
         if (fwd_valid && eng_ready[fwd_engine]) begin
            got = 1; ge = fwd_engine; gs = fwd_subch; gm = fwd_method; gp = fwd_param;
         end
         if (notify_irq) notif = 1;
         if (cmd_ready || err_flag) break;
         @(negedge clk);
      end
      if (k <= 1) begin
         if (tgt == 5'(SW)) begin
            chk(!got, "R6", "forward to software id", {31'd0, got}, 32'd0);
            chk(err_flag && err_code == 2'd1, "R6", "empty-subchannel error",
                {30'd0, err_code}, 32'd1);
            clear_err();
         end else begin
            chk(got, (k == 0) ? "R2" : "R3", "forward seen", {31'd0, got}, 32'd1);
            chk(ge == tgt, (k == 0) ? "R2" : "R3", "engine", {27'd0, ge}, {27'd0, tgt});
            chk(gs == s && gm == m, (k == 0) ? "R2" : "R3", "subch/method",
                {15'd0, gs, gm}, {15'd0, s, m});
            chk(gp == f_fparam(k, p), (k == 0) ? "R2" : "R3", "param", gp, f_fparam(k, p));
            if (k == 0) mb[s] = tgt;
            ml = tgt;
         end
      end else begin
         chk(!got, "R9", "built-in forwards nothing", {31'd0, got}, 32'd0);
         chk(notif == (k == 3), "R9", "notify pulse", {31'd0, notif}, {31'd0, k == 3});
         if (k == 4) mref = p;
         chk(ref_count == mref, (k == 4) ? "R8" : "R9", "ref_count", ref_count, mref);
      end
   endtask

   task automatic do_cmd(input logic [2:0] s, input logic [13:0] m, input logic [31:0] p);
      issue(s, m, p);
      finish_cmd(s, m, p);
   endtask

   initial begin
      bit stall_ok;
      bit hold_ok;
      logic [31:0] hp;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 8; i++) mb[i] = 5'(SW);
      ml = 5'(SW);
      mref = '0;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_ready && !fwd_valid && !notify_irq, "R1", "ready/valid/notify after reset",
          {29'd0, cmd_ready, fwd_valid, notify_irq}, 32'h4);
      chk(!err_flag && err_code == 2'd0 && ref_count == 0, "R1", "err/ref after reset",
          ref_count, 32'd0);

      // R1 R6: fresh subchannel is bound to the software id
      do_cmd(3'd3, 14'h104, 32'hCAFE0001);

      // R7: error holds and blocks until cleared
      issue(3'd0, 14'h200, 32'h1);
      repeat (3) @(negedge clk);
      for (int i = 0; i < 5; i++) begin
         chk(err_flag && !cmd_ready, "R7", "sticky error blocks input",
             {30'd0, err_flag, cmd_ready}, 32'h2);
         @(negedge clk);
      end
      clear_err();

      // R2: bind with extra high bits in the parameter
      do_cmd(3'd1, 14'h000, 32'hFFE3BEEF);
      do_cmd(3'd1, 14'h104, 32'h11112222);
      do_cmd(3'd2, 14'h000, 32'h00050042);
      do_cmd(3'd2, 14'h3FFC, 32'hA5A5A5A5);

      // R5: switching from engine 5 to 3 stalls while 5 is busy
      eng_idle[5] = 1'b0;
      issue(3'd1, 14'h180, 32'h00000033);
      stall_ok = 1;
      for (int i = 0; i < 10; i++) begin
         if (fwd_valid) stall_ok = 0;
         @(negedge clk);
      end
      chk(stall_ok, "R5", "no forward while last engine busy", {31'd0, stall_ok}, 32'd1);
      eng_idle[5] = 1'b1;
      finish_cmd(3'd1, 14'h180, 32'h00000033);

      // R5: same engine does not wait for idle
      eng_idle[3] = 1'b0;
      do_cmd(3'd1, 14'h184, 32'h00000044);

      // R8: reference load drains the last engine first
      issue(3'd0, 14'h050, 32'h12345678);
      for (int i = 0; i < 8; i++) @(negedge clk);
      chk(ref_count == mref, "R8", "ref held while engine busy", ref_count, mref);
      eng_idle[3] = 1'b1;
      finish_cmd(3'd0, 14'h050, 32'h12345678);

      // R4: backpressure holds forward fields
      eng_ready[3] = 1'b0;
      issue(3'd1, 14'h1F0, 32'h0BADF00D);
      while (!fwd_valid) @(negedge clk);
      hp = fwd_param;
      hold_ok = 1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (!fwd_valid || fwd_param != hp || fwd_engine != 5'd3 || fwd_method != 14'h1F0)
            hold_ok = 0;
      end
      chk(hold_ok, "R4", "forward held under backpressure", {31'd0, hold_ok}, 32'd1);
      eng_ready[3] = 1'b1;
      finish_cmd(3'd1, 14'h1F0, 32'h0BADF00D);

      // R6: bind to software id keeps old binding
      do_cmd(3'd1, 14'h000, 32'h0000BEEF);
      do_cmd(3'd1, 14'h108, 32'h00000055);

      // R9: notify, nop, unnamed built-in
      do_cmd(3'd4, 14'h020, 32'h0);
      do_cmd(3'd4, 14'h008, 32'hFFFFFFFF);
      do_cmd(3'd4, 14'h02C, 32'h77777777);

      for (int i = 0; i < 400; i++) begin
         int r = int'($urandom % 10);
         logic [2:0] s = 3'($urandom % 8);
         logic [31:0] p = $urandom;
         logic [13:0] m;
         if (r < 3) begin
            m = 14'h000;
            p[20:16] = ($urandom % 8 == 0) ? 5'(SW) : 5'(1 + $urandom % 31);
         end else if (r < 7) begin
            m = 14'(4 * (32'h40 + $urandom % 32'hFC0));
         end else if (r == 7) begin
            m = 14'(4 * ($urandom % 64));
         end else if (r == 8) begin
            m = 14'h020;
         end else begin
            m = 14'h050;
         end
         do_cmd(s, m, p);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule